// File: doc/BRIEF.md
# Debug Breakpoint and Trace-Alignment Controller

This block sits between a comparator-driven debug state sequencer and the CPU. It watches for the moment the sequencer reaches its final state, either through a comparator channel or through a software trigger written together with the arm bit. It then decides three things: when the trace recorder starts and stops, when the unit disarms, and whether and when a breakpoint is requested. The trace memory itself is outside the block. The block only emits one-cycle start and stop pulses and a level that says whether entries should be recorded now.

Alignment sets the timing. With end alignment the recorder runs from arming up to the trigger, and the trigger closes the session. With begin alignment the trigger opens recording, and the session closes when the buffer reports full. Further triggers during that session are ignored. An immediate-break setting closes the session on the trigger whatever the alignment. A channel in tag mode counts only when the tagged opcode is reported as reaching execution.

Each breakpoint request goes either to the debug monitor or to the software-interrupt path. No request is made while the monitor is active. A software-interrupt request is dropped when a background instruction executes in the same cycle with the monitor enabled.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset all outputs are 0 and the unit is idle. While idle, comparator events have no effect until an arm write arrives (`cfg_wr`=1 with `cfg_arm`=1).
- R2: With `trace_en`=0, a final-state event while armed gives `disarm`=1 and, if `brk_en`=1, a breakpoint pulse, both in the cycle after the event. No `trace_stop` pulse is produced.
- R3: With `trace_en`=1, `align_end`=1 and `brk_now`=0, arming pulses `trace_start` and holds `trace_rec`=1. The trigger then gives `trace_stop`, `disarm` and (if `brk_en`=1) a breakpoint, all in the next cycle, and `trace_rec` falls.
- R4: As R3 but with `brk_en`=0: the trigger gives `trace_stop` and `disarm` with no breakpoint.
- R5: With `trace_en`=1, `align_end`=0, `brk_now`=0 and `brk_en`=1, the trigger pulses `trace_start` and sets `trace_rec`=1. The breakpoint comes only in the cycle after `buf_full`=1, together with `trace_stop` and `disarm`.
- R6: As R5 but with `brk_en`=0: buffer full gives `trace_stop` and `disarm` and no breakpoint.
- R7: With `trace_en`=1 and `brk_now`=1, the trigger gives `trace_stop` and `disarm` in the next cycle under either alignment, with no `trace_start`. A breakpoint is added when `brk_en`=1.
- R8: A write with `cfg_arm`=1 and `cfg_trig`=1 is a final-state event. It takes effect in the same write when the unit was idle, and likewise when the unit was already armed.
- R9: While begin-aligned recording is running, software triggers and comparator events change no output. `trace_rec` stays 1 until buffer full.
- R10: A channel whose `cmp_tag` bit is 1 triggers only in a cycle with `tag_exec`=1, and then the breakpoint comes in the very next cycle. Any channel of `cmp_final` can trigger.
- R11: A request goes to `brk_mon` when `route_mon`=1 and `mon_en`=1, and to `brk_swi` otherwise. The two are never high together, and each request is a single-cycle pulse.
- R12: A software-interrupt request is dropped when `bgnd_exec`=1 and `mon_en`=1 in the cycle of the event; the session still disarms.
- R13: While `mon_active`=1, comparator events are ignored and no breakpoint is output. A software trigger still ends the session.
- R14: A write with `cfg_arm`=0 while armed or recording aborts the session. It gives `disarm` and gives `trace_stop` if recording was on, with no breakpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_arm | input | 1 | Arm bit of the write (0 aborts) |
| cfg_trig | input | 1 | Software trigger bit of the write |
| cmp_final | input | CH_NUM | Per-channel final-state match |
| cmp_tag | input | CH_NUM | Per-channel tag-mode flag |
| tag_exec | input | 1 | Tagged opcode reaching execution |
| trace_en | input | 1 | A trace session is selected |
| align_end | input | 1 | 1 = end alignment, 0 = begin alignment |
| brk_en | input | 1 | Breakpoints enabled |
| brk_now | input | 1 | Immediate break on trigger |
| route_mon | input | 1 | Route breakpoints to the debug monitor |
| buf_full | input | 1 | Trace buffer full |
| mon_en | input | 1 | Debug monitor enabled |
| mon_active | input | 1 | Debug monitor currently active |
| bgnd_exec | input | 1 | Background instruction executing |
| trace_start | output | 1 | Pulse: recording begins |
| trace_stop | output | 1 | Pulse: recording ends |
| trace_rec | output | 1 | Level: record entries now |
| disarm | output | 1 | Pulse: session ended, unit disarmed |
| brk_mon | output | 1 | Pulse: breakpoint to debug monitor |
| brk_swi | output | 1 | Pulse: breakpoint to software interrupt |

## Verification
Two functions can land in the same cycle. The first is a software-interrupt breakpoint together with a background instruction under an enabled monitor. The second is a trigger, software or comparator, that arrives while begin-aligned recording is already open. The bench sets `bgnd_exec` in the exact cycle of the final-state event and expects `disarm` with `brk_swi` low. A control case with the monitor disabled must keep the pulse. It also writes arm-plus-trigger and fires a comparator during a begin-aligned session and expects every output frozen with `trace_rec` high, after which buffer full alone produces the breakpoint.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TRACE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic trace_en;
        logic align_end;
        logic brk_en;
        logic brk_now;
        logic route_mon;
    } brk_cfg_t;

    typedef struct packed {
        logic arm;
        logic abort;
        logic sw;
        logic hw;
    } trig_evt_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rec;
    } trc_ctl_t;

    typedef struct packed {
        logic en;
        logic active;
        logic bgnd;
    } mon_ctx_t;

    function automatic logic brk_at_trigger(brk_cfg_t c);
        return c.brk_en & (~c.trace_en | c.brk_now | c.align_end);
    endfunction

    function automatic logic opens_trace(brk_cfg_t c);
        return c.trace_en & ~c.brk_now & ~c.align_end;
    endfunction

    function automatic logic records_armed(brk_cfg_t c);
        return c.trace_en & c.align_end;
    endfunction

endpackage

// File: rtl/dbg_trig_qual.sv
module dbg_trig_qual
    import dbg_brk_pkg::*;
#(
    parameter int CH_NUM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_trig,
    input  logic [CH_NUM-1:0] cmp_final,
    input  logic [CH_NUM-1:0] cmp_tag,
    input  logic              tag_exec,
    input  logic              mon_active,
    output trig_evt_t         evt
);

    logic [CH_NUM-1:0] ch_hit;

    generate
        for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
            always_comb begin
                if (cmp_tag[i]) begin
                    ch_hit[i] = cmp_final[i] & tag_exec;
                end else begin
                    ch_hit[i] = cmp_final[i];
                end
            end
        end
    endgenerate

    always_comb begin
        evt.arm   = cfg_wr & cfg_arm;
        evt.abort = cfg_wr & ~cfg_arm;
        evt.sw    = cfg_wr & cfg_arm & cfg_trig;
        evt.hw    = (|ch_hit) & ~mon_active;
    end

    AST_TAG_WAITS_EXEC: assert property (@(posedge clk) disable iff (rst)
        (((cmp_final & ~cmp_tag) == '0) && !tag_exec) |-> !evt.hw) // R10
        else $error("tagged channel triggered without execution flag");

    AST_MON_BLOCKS_CMP: assert property (@(posedge clk) disable iff (rst)
        mon_active |-> !evt.hw) // R13
        else $error("comparator event passed while monitor active");

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
    import dbg_brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  brk_cfg_t  cfg,
    input  trig_evt_t evt,
    input  logic      buf_full,
    output trc_ctl_t  trc,
    output logic      disarm_o,
    output logic      brk_raw
);

    seq_state_t st, nxt;
    trc_ctl_t   trc_q;
    logic       dis_q;
    logic       live, hit, rec_now;
    logic       n_start, n_stop, n_dis, n_rec;

    always_comb begin
        live    = (st == ST_ARMED) | ((st == ST_IDLE) & evt.arm);
        hit     = live & (evt.hw | evt.sw);
        rec_now = (st == ST_TRACE) | ((st == ST_ARMED) & records_armed(cfg));
        nxt     = st;
        n_start = 1'b0;
        n_stop  = 1'b0;
        n_dis   = 1'b0;
        brk_raw = 1'b0;
        if (evt.abort && (st != ST_IDLE)) begin
            nxt    = ST_IDLE;
            n_stop = rec_now;
            n_dis  = 1'b1;
        end else if (hit) begin
            if (opens_trace(cfg)) begin
                nxt     = ST_TRACE;
                n_start = 1'b1;
            end else begin
                nxt     = ST_IDLE;
                n_stop  = cfg.trace_en;
                n_dis   = 1'b1;
                brk_raw = brk_at_trigger(cfg);
            end
        end else if ((st == ST_IDLE) && evt.arm) begin
            nxt     = ST_ARMED;
            n_start = records_armed(cfg);
        end else if ((st == ST_TRACE) && buf_full) begin
            nxt     = ST_IDLE;
            n_stop  = 1'b1;
            n_dis   = 1'b1;
            brk_raw = cfg.brk_en;
        end
        n_rec = (nxt == ST_TRACE) | ((nxt == ST_ARMED) & records_armed(cfg));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            trc_q <= '0;
            dis_q <= 1'b0;
        end else begin
            st          <= nxt;
            trc_q.start <= n_start;
            trc_q.stop  <= n_stop;
            trc_q.rec   <= n_rec;
            dis_q       <= n_dis;
        end
    end

    assign trc      = trc_q;
    assign disarm_o = dis_q;

    AST_TRACE_IGNORES_TRIG: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TRACE && !buf_full && !evt.abort) |=> (st == ST_TRACE && !dis_q && trc_q.rec)) // R9
        else $error("begin-aligned session disturbed by trigger");

    AST_NOTRACE_DISARM: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && (evt.hw || evt.sw) && !evt.abort && !cfg.trace_en) |=> (dis_q && !trc_q.stop && st == ST_IDLE)) // R2
        else $error("untraced trigger did not end session");

    AST_END_FILL_STOP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && (evt.hw || evt.sw) && !evt.abort && cfg.trace_en && cfg.align_end) |=> (dis_q && trc_q.stop && !trc_q.rec)) // R3
        else $error("end-aligned trigger did not stop trace");

    AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && (evt.hw || evt.sw) && !evt.abort && cfg.trace_en && !cfg.align_end && !cfg.brk_now) |=> (st == ST_TRACE && trc_q.start && trc_q.rec && !dis_q)) // R5
        else $error("begin-aligned trigger did not open trace");

    AST_NOW_NO_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && (evt.hw || evt.sw) && !evt.abort && cfg.trace_en && cfg.brk_now) |=> (trc_q.stop && !trc_q.start && dis_q)) // R7
        else $error("immediate break did not terminate trace");

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && evt.abort) |=> (dis_q && st == ST_IDLE && !trc_q.rec)) // R14
        else $error("abort write did not end session");

endmodule

// File: rtl/dbg_brk_arb.sv
module dbg_brk_arb
    import dbg_brk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     brk_raw,
    input  logic     route_mon,
    input  mon_ctx_t mon,
    output logic     brk_mon_o,
    output logic     brk_swi_o
);

    logic mon_path, allow, swi_kill;

    always_comb begin
        allow    = brk_raw & ~mon.active;
        mon_path = route_mon & mon.en;
        swi_kill = mon.bgnd & mon.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_mon_o <= 1'b0;
            brk_swi_o <= 1'b0;
        end else begin
            brk_mon_o <= allow & mon_path;
            brk_swi_o <= allow & ~mon_path & ~swi_kill;
        end
    end

    AST_MON_QUIET: assert property (@(posedge clk) disable iff (rst)
        mon.active |=> (!brk_mon_o && !brk_swi_o)) // R13
        else $error("breakpoint while monitor active");

    AST_SWI_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (mon.bgnd && mon.en) |=> !brk_swi_o) // R12
        else $error("software interrupt not dropped on background instruction");

    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({brk_mon_o, brk_swi_o})) // R11
        else $error("breakpoint routed to both paths");

    AST_MON_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (brk_raw && !mon.active && route_mon && mon.en) |=> (brk_mon_o && !brk_swi_o)) // R11
        else $error("monitor-routed request lost");

endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
    import dbg_brk_pkg::*;
#(
    parameter int CH_NUM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_arm,
    input  logic              cfg_trig,
    input  logic [CH_NUM-1:0] cmp_final,
    input  logic [CH_NUM-1:0] cmp_tag,
    input  logic              tag_exec,
    input  logic              trace_en,
    input  logic              align_end,
    input  logic              brk_en,
    input  logic              brk_now,
    input  logic              route_mon,
    input  logic              buf_full,
    input  logic              mon_en,
    input  logic              mon_active,
    input  logic              bgnd_exec,
    output logic              trace_start,
    output logic              trace_stop,
    output logic              trace_rec,
    output logic              disarm,
    output logic              brk_mon,
    output logic              brk_swi
);

    brk_cfg_t  cfg;
    mon_ctx_t  mon;
    trig_evt_t evt;
    trc_ctl_t  trc;
    logic      brk_raw;

    always_comb begin
        cfg.trace_en  = trace_en;
        cfg.align_end = align_end;
        cfg.brk_en    = brk_en;
        cfg.brk_now   = brk_now;
        cfg.route_mon = route_mon;
        mon.en        = mon_en;
        mon.active    = mon_active;
        mon.bgnd      = bgnd_exec;
    end

    dbg_trig_qual #(.CH_NUM(CH_NUM)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_arm    (cfg_arm),
        .cfg_trig   (cfg_trig),
        .cmp_final  (cmp_final),
        .cmp_tag    (cmp_tag),
        .tag_exec   (tag_exec),
        .mon_active (mon_active),
        .evt        (evt)
    );

    dbg_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .evt      (evt),
        .buf_full (buf_full),
        .trc      (trc),
        .disarm_o (disarm),
        .brk_raw  (brk_raw)
    );

    dbg_brk_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .brk_raw   (brk_raw),
        .route_mon (cfg.route_mon),
        .mon       (mon),
        .brk_mon_o (brk_mon),
        .brk_swi_o (brk_swi)
    );

    assign trace_start = trc.start;
    assign trace_stop  = trc.stop;
    assign trace_rec   = trc.rec;

    AST_BRK_ENDS_SESSION: assert property (@(posedge clk) disable iff (rst)
        (brk_mon || brk_swi) |-> disarm) // R3
        else $error("breakpoint without session end");

    AST_START_STOP_APART: assert property (@(posedge clk) disable iff (rst)
        !(trace_start && trace_stop)) // R8
        else $error("start and stop in one cycle");

endmodule

// File: tb/dbg_brk_ctrl_tb.sv
module dbg_brk_ctrl_tb_top;

    localparam int CH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 0, cfg_arm = 0, cfg_trig = 0;
    logic [CH-1:0] cmp_final = '0, cmp_tag = '0;
    logic tag_exec = 0, trace_en = 0, align_end = 0, brk_en = 0, brk_now = 0;
    logic route_mon = 0, buf_full = 0, mon_en = 0, mon_active = 0, bgnd_exec = 0;
    logic trace_start, trace_stop, trace_rec, disarm, brk_mon, brk_swi;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dbg_brk_ctrl #(.CH_NUM(CH)) dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_arm(cfg_arm), .cfg_trig(cfg_trig),
        .cmp_final(cmp_final), .cmp_tag(cmp_tag), .tag_exec(tag_exec),
        .trace_en(trace_en), .align_end(align_end), .brk_en(brk_en), .brk_now(brk_now),
        .route_mon(route_mon), .buf_full(buf_full), .mon_en(mon_en),
        .mon_active(mon_active), .bgnd_exec(bgnd_exec),
        .trace_start(trace_start), .trace_stop(trace_stop), .trace_rec(trace_rec),
        .disarm(disarm), .brk_mon(brk_mon), .brk_swi(brk_swi)
    );

    // observed order: start, stop, rec, disarm, brk_mon, brk_swi
    // vector: {trace_en, align_end, brk_en, brk_now, after-trigger[5:0], after-full[5:0]}
    localparam logic [15:0] VEC [8] = '{
        16'b0010_000101_000000,   // R2 no trace, break
        16'b0000_000100_000000,   // R2 no trace, no break
        16'b1110_010101_000000,   // R3 end, break
        16'b1100_010100_000000,   // R4 end, no break
        16'b1010_101000_010101,   // R5 begin, break at full
        16'b1000_101000_010100,   // R6 begin, no break
        16'b1011_010101_000000,   // R7 immediate, begin
        16'b1101_010100_000000    // R7 immediate, end
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {trace_start, trace_stop, trace_rec, disarm, brk_mon, brk_swi};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [3:0] c);
        {trace_en, align_end, brk_en, brk_now} = c;
    endtask

    task automatic write(input logic a, input logic t);
        cfg_wr = 1; cfg_arm = a; cfg_trig = t;
        tick();
        cfg_wr = 0; cfg_arm = 0; cfg_trig = 0;
    endtask

    task automatic fire(input int ch);
        cmp_final = '0;
        cmp_final[ch] = 1'b1;
        tick();
        cmp_final = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 reset", 6'b000000);
        fire(0);
        chk("R1 idle ignores comparator", 6'b000000);

        for (int v = 0; v < 8; v++) begin
            logic [5:0] ex_arm;
            set_cfg(VEC[v][15:12]);
            ex_arm = {VEC[v][15] & VEC[v][14], 1'b0, VEC[v][15] & VEC[v][14], 3'b000};
            write(1, 0);
            chk($sformatf("R3 arm vec%0d", v), ex_arm);
            tick();
            chk($sformatf("R3 armed vec%0d", v), {1'b0, 1'b0, ex_arm[3], 3'b000});
            fire(v % CH);
            chk($sformatf("R2-R7 trigger vec%0d", v), VEC[v][11:6]);
            if (VEC[v][11]) begin
                tick();
                chk($sformatf("R5 recording vec%0d", v), 6'b001000);
                buf_full = 1;
                tick();
                buf_full = 0;
                chk($sformatf("R6 full vec%0d", v), VEC[v][5:0]);
            end
            tick();
            chk($sformatf("R11 pulse ends vec%0d", v), 6'b000000);
        end

        // R8 software trigger while armed, and arm+trigger from idle
        set_cfg(4'b1110);
        write(1, 0);
        tick();
        write(1, 1);
        chk("R8 sw trigger armed", 6'b010101);
        tick();
        write(1, 1);
        chk("R8 arm+trig one write", 6'b010101);
        tick();

        // R9 triggers ignored during begin-aligned recording
        set_cfg(4'b1010);
        write(1, 0);
        fire(1);
        chk("R9 open", 6'b101000);
        write(1, 1);
        chk("R9 sw trigger ignored", 6'b001000);
        fire(3);
        chk("R9 comparator ignored", 6'b001000);
        buf_full = 1;
        tick();
        buf_full = 0;
        chk("R9 break at full", 6'b010101);
        tick();

        // R10 tagged channel waits for execution flag
        set_cfg(4'b1110);
        write(1, 0);
        tick();
        cmp_tag = 4'b0100;
        fire(2);
        chk("R10 tag without exec", 6'b001000);
        tag_exec = 1;
        fire(2);
        tag_exec = 0;
        cmp_tag = '0;
        chk("R10 tagged break next cycle", 6'b010101);
        tick();

        // R11 routing to monitor, single cycle
        set_cfg(4'b0010);
        route_mon = 1; mon_en = 1;
        write(1, 0);
        fire(0);
        chk("R11 monitor route", 6'b000110);
        tick();
        chk("R11 single pulse", 6'b000000);
        mon_en = 0;
        write(1, 0);
        fire(0);
        chk("R11 monitor disabled goes swi", 6'b000101);
        route_mon = 0;
        tick();

        // R12 background instruction with monitor enabled drops swi
        mon_en = 1; bgnd_exec = 1;
        write(1, 0);
        fire(1);
        chk("R12 swi dropped", 6'b000100);
        mon_en = 0;
        write(1, 0);
        fire(1);
        chk("R12 swi kept monitor off", 6'b000101);
        bgnd_exec = 0;
        tick();

        // R13 monitor active
        set_cfg(4'b1110);
        mon_active = 1;
        write(1, 0);
        chk("R13 arm", 6'b101000);
        fire(0);
        chk("R13 comparator ignored", 6'b001000);
        write(1, 1);
        chk("R13 sw trigger no break", 6'b010100);
        mon_active = 0;
        tick();

        // R14 abort writes
        write(1, 0);
        tick();
        write(0, 0);
        chk("R14 abort end-aligned", 6'b010100);
        set_cfg(4'b1010);
        write(1, 0);
        fire(0);
        write(0, 0);
        chk("R14 abort begin session", 6'b010100);
        tick();
        chk("R14 idle after abort", 6'b000000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule